// File: doc/BRIEF.md
# Microcontroller Interrupt Request Controller

This block gathers interrupt events for a small 8-bit processor core and decides when the core should jump to its interrupt handler. It has ten sources. The first is an external pin whose active edge can be chosen. The second is a pin-change pulse and the third is a timer overflow pulse. The remaining seven are peripheral pulses. Every source owns a sticky flag and an enable bit. The seven peripheral sources are gated as a group by a group enable. The whole request is gated by a global enable.

Software sees all of this through four byte-wide registers, with one write port and one read port. The core receives a level request, plus a one-cycle dispatch pulse that also tells it to push its return address. The core also receives the fixed handler address. Dispatch clears the global enable. A return strobe from the core sets it again. A clear strobe from the core cancels a dispatch that would otherwise occur in the same cycle, and the pending flag is kept. A separate wake output tells a sleeping core that an enabled, wake-capable event is pending. This output works whatever the global enable is.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_req_o`, `vec_take_o` and `wake_o` are 0.
- R2: A source event sets its flag at the next clock edge, whatever its enable, the group enable or the global enable.
- R3: A flag stays set until software writes 0 to it. An event in the same cycle as that write wins, and the flag stays 1.
- R4: `irq_req_o` = global enable AND (any core flag&enable OR (group enable AND any peripheral flag&enable)). It is combinational from the register state.
- R5: When `irq_req_o` is 1 and `gie_clr_i` is 0, `vec_take_o` is 1 in the next cycle, for one cycle only. The global enable then reads 0. `vec_addr_o` is always 0x0004.
- R6: A `gie_clr_i` strobe in a cycle where a dispatch would occur blocks that dispatch and clears the global enable. The flag stays pending and is dispatched after the global enable is set again.
- R7: An `rfi_i` strobe sets the global enable at the next edge. A flag that was left set then raises the request again at once.
- R8: Register 3 bit 0 selects the edge of the external pin: 1 selects rising, 0 selects falling. The external flag sets on the third clock edge after the pin changes. This counts two synchronizer stages and the edge stage. The opposite edge never sets the flag.
- R9: While register 3 bit 1 (analog mode) is 1, the pin reads as 0 and no pin movement sets the external flag.
- R10: `wake_o` is 1 whenever a wake-capable source has both its flag and its enable set, whatever the global enable. By default the timer is not wake-capable. Peripheral terms also need the group enable.
- R11: Register map. Address 0 holds, from bit 7 down: global enable, group enable, external enable, timer enable, pin-change enable, external flag, timer flag, pin-change flag. Address 1 bits 6:0 are the peripheral flags. Address 2 bits 6:0 are the peripheral enables. Address 3 bits 1:0 are analog mode and edge select. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| chg_evt_i | input | 1 | Pin-change event pulse |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| periph_evt_i | input | N_PERIPH (7) | Peripheral event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| gie_clr_i | input | 1 | Core strobe that clears the global enable |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Level interrupt request |
| vec_take_o | output | 1 | Dispatch pulse (push return address, load vector) |
| vec_addr_o | output | VEC_W (13) | Handler address |
| wake_o | output | 1 | Wake-from-sleep request |

## Verification
Flags from the pulse sources can be read one edge after their event. `irq_req_o`, `wake_o` and the read data follow the register state in the same cycle. `vec_take_o` appears one edge after the request is seen. The external pin flag appears three edges after the pin moves. The bench drives inputs on the falling clock edge and samples just after it. It keeps a cycle model that is advanced once per rising edge, so every comparison is made exactly one edge after the stimulus that caused it. Directed pin sequences check the flag just before and just on its third edge.

// File: rtl/irq_pkg.sv
// Shared constants for the interrupt request controller: register
// addresses, bit positions inside the core register and source indices.
package irq_pkg;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        REG_CORE  = 2'd0,
        REG_PFLAG = 2'd1,
        REG_PEN   = 2'd2,
        REG_PIN   = 2'd3
    } reg_sel_e;

    // bit positions in the core register
    localparam int unsigned CB_GIE    = 7;
    localparam int unsigned CB_PGE    = 6;
    localparam int unsigned CB_EXT_EN = 5;
    localparam int unsigned CB_TMR_EN = 4;
    localparam int unsigned CB_CHG_EN = 3;
    localparam int unsigned CB_EXT_F  = 2;
    localparam int unsigned CB_TMR_F  = 1;
    localparam int unsigned CB_CHG_F  = 0;

    // bit positions in the pin control register
    localparam int unsigned PB_EDGE   = 0;
    localparam int unsigned PB_ANALOG = 1;

    // core source indices
    localparam int unsigned SRC_EXT = 0;
    localparam int unsigned SRC_TMR = 1;
    localparam int unsigned SRC_CHG = 2;
    localparam int unsigned N_CORE  = 3;
endpackage

// File: rtl/irq_pin_edge.sv
// Synchronizes the external pin and detects the selected edge.
// Assumes: the pin is asynchronous; analog mode forces the pin to read 0
// and suppresses any edge; edge_o is a one-cycle pulse.
module irq_pin_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    input  logic analog_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    // shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign level = sync_q[SYNC_STAGES-1] & ~analog_i;

    // remember the previous masked level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // pick the active transition, none in analog mode
    always_comb begin
        if (analog_i)        edge_o = 1'b0;
        else if (rise_sel_i) edge_o = level & ~prev_q;
        else                 edge_o = ~level & prev_q;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// A bank of sticky flags. A set pulse has priority over a software write,
// so an event is never lost when it meets a clearing write.
module irq_flag_bank #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic [N-1:0] wr_val_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // hold, set on event, or take the software value
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (wr_i)     flag_o[i] <= wr_val_i[i];
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
// Interrupt request controller top. It holds the enable registers and the
// global enable, combines flags into the request and wake outputs, and
// issues the dispatch pulse.
// Assumes: N_PERIPH <= 8, and the event inputs are synchronous one-cycle
// pulses.
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned N_PERIPH    = 7,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VEC_W       = 13,
    parameter logic [VEC_W-1:0] VECTOR_ADDR = 'h4,
    parameter logic [N_CORE+N_PERIPH-1:0] WAKE_MASK = {{N_PERIPH{1'b1}}, 3'b101}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_pin_i,
    input  logic                chg_evt_i,
    input  logic                tmr_ovf_i,
    input  logic [N_PERIPH-1:0] periph_evt_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [1:0]          rd_addr_i,
    output logic [DATA_W-1:0]   rd_data_o,
    input  logic                gie_clr_i,
    input  logic                rfi_i,
    output logic                irq_req_o,
    output logic                vec_take_o,
    output logic [VEC_W-1:0]    vec_addr_o,
    output logic                wake_o
);
    localparam logic [N_CORE-1:0]   CORE_WAKE = WAKE_MASK[N_CORE-1:0];
    localparam logic [N_PERIPH-1:0] PER_WAKE  = WAKE_MASK[N_CORE+N_PERIPH-1:N_CORE];

    logic [N_CORE-1:0]   core_set, core_wr_val, core_flag, core_en_q;
    logic [N_PERIPH-1:0] pflag, pen_q;
    logic gie_q, pge_q, edge_sel_q, analog_q, vec_q, ext_edge;
    logic wr_core, wr_pflag, wr_pen, wr_pin, take;
    logic core_any, per_any;

    assign wr_core  = wr_en_i && (wr_addr_i == REG_CORE);
    assign wr_pflag = wr_en_i && (wr_addr_i == REG_PFLAG);
    assign wr_pen   = wr_en_i && (wr_addr_i == REG_PEN);
    assign wr_pin   = wr_en_i && (wr_addr_i == REG_PIN);

    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin_i),
        .rise_sel_i (edge_sel_q),
        .analog_i   (analog_q),
        .edge_o     (ext_edge)
    );

    // route events and written values to core source indices
    always_comb begin
        core_set[SRC_EXT]    = ext_edge;
        core_set[SRC_TMR]    = tmr_ovf_i;
        core_set[SRC_CHG]    = chg_evt_i;
        core_wr_val[SRC_EXT] = wr_data_i[CB_EXT_F];
        core_wr_val[SRC_TMR] = wr_data_i[CB_TMR_F];
        core_wr_val[SRC_CHG] = wr_data_i[CB_CHG_F];
    end

    irq_flag_bank #(.N(N_CORE)) u_core_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (core_set),
        .wr_i     (wr_core),
        .wr_val_i (core_wr_val),
        .flag_o   (core_flag)
    );

    irq_flag_bank #(.N(N_PERIPH)) u_per_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (periph_evt_i),
        .wr_i     (wr_pflag),
        .wr_val_i (wr_data_i[N_PERIPH-1:0]),
        .flag_o   (pflag)
    );

    // enable and pin control registers, written by software only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en_q  <= '0;
            pge_q      <= 1'b0;
            pen_q      <= '0;
            edge_sel_q <= 1'b0;
            analog_q   <= 1'b0;
        end else begin
            if (wr_core) begin
                core_en_q[SRC_EXT] <= wr_data_i[CB_EXT_EN];
                core_en_q[SRC_TMR] <= wr_data_i[CB_TMR_EN];
                core_en_q[SRC_CHG] <= wr_data_i[CB_CHG_EN];
                pge_q              <= wr_data_i[CB_PGE];
            end
            if (wr_pen) pen_q <= wr_data_i[N_PERIPH-1:0];
            if (wr_pin) begin
                edge_sel_q <= wr_data_i[PB_EDGE];
                analog_q   <= wr_data_i[PB_ANALOG];
            end
        end
    end

    assign core_any  = |(core_flag & core_en_q);
    assign per_any   = pge_q & (|(pflag & pen_q));
    assign irq_req_o = gie_q & (core_any | per_any);
    assign take      = irq_req_o & ~gie_clr_i;

    // global enable: dispatch and clear strobe beat return, return beats software
    always_ff @(posedge clk) begin
        if (!rst_n)                gie_q <= 1'b0;
        else if (take | gie_clr_i) gie_q <= 1'b0;
        else if (rfi_i)            gie_q <= 1'b1;
        else if (wr_core)          gie_q <= wr_data_i[CB_GIE];
    end

    // register the dispatch pulse for the core
    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= 1'b0;
        else        vec_q <= take;
    end

    assign vec_take_o = vec_q;
    assign vec_addr_o = VECTOR_ADDR;
    assign wake_o     = (|(core_flag & core_en_q & CORE_WAKE))
                      | (pge_q & (|(pflag & pen_q & PER_WAKE)));

    // register read multiplexer
    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            REG_CORE: begin
                rd_data_o[CB_GIE]    = gie_q;
                rd_data_o[CB_PGE]    = pge_q;
                rd_data_o[CB_EXT_EN] = core_en_q[SRC_EXT];
                rd_data_o[CB_TMR_EN] = core_en_q[SRC_TMR];
                rd_data_o[CB_CHG_EN] = core_en_q[SRC_CHG];
                rd_data_o[CB_EXT_F]  = core_flag[SRC_EXT];
                rd_data_o[CB_TMR_F]  = core_flag[SRC_TMR];
                rd_data_o[CB_CHG_F]  = core_flag[SRC_CHG];
            end
            REG_PFLAG: rd_data_o[N_PERIPH-1:0] = pflag;
            REG_PEN:   rd_data_o[N_PERIPH-1:0] = pen_q;
            REG_PIN: begin
                rd_data_o[PB_EDGE]   = edge_sel_q;
                rd_data_o[PB_ANALOG] = analog_q;
            end
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
// Temporal checks on the interrupt request controller, attached by bind.
module irq_ctrl_chk
    import irq_pkg::*;
#(
    parameter int unsigned N_PERIPH = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                gie,
    input logic                req,
    input logic                take,
    input logic                wake,
    input logic                clr,
    input logic                rfi,
    input logic                tmr_evt,
    input logic [N_CORE-1:0]   core_flag,
    input logic [N_PERIPH-1:0] pflag,
    input logic [N_PERIPH-1:0] pevt
);
    a_r5_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    a_r5_take_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && take) |-> ($past(req) && !$past(clr)));

    a_r5_gie_off_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !gie);

    a_r6_clr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr)) |-> (!take && !gie));

    a_r4_no_req_without_gie: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !req);

    a_r2_tmr_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tmr_evt)) |-> core_flag[SRC_TMR]);

    a_r2_per_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pflag & $past(pevt)) == $past(pevt)));

    a_r7_rfi_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rfi) && !$past(clr) && !$past(req)) |-> gie);

    a_r10_no_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (core_flag == '0 && pflag == '0) |-> !wake);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_PERIPH(N_PERIPH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie       (gie_q),
    .req       (irq_req_o),
    .take      (vec_take_o),
    .wake      (wake_o),
    .clr       (gie_clr_i),
    .rfi       (rfi_i),
    .tmr_evt   (tmr_ovf_i),
    .core_flag (core_flag),
    .pflag     (pflag),
    .pevt      (periph_evt_i)
);

// File: tb/irq_ctrl_bench.sv
// Bench: directed corner cases, then seeded random traffic compared with a
// cycle model built from the requirements.
module irq_ctrl_bench;
    localparam int unsigned NP = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin = 1'b0, chg = 1'b0, tmr = 1'b0, wr_en = 1'b0, clr = 1'b0, rfi = 1'b0;
    logic [NP-1:0] pevt = '0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic req, take, wake;
    logic [12:0] vaddr;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 0;

    // cycle model (index 0 ext, 1 timer, 2 pin change)
    logic [2:0] mf, men;
    logic mgie, mpge, mvec;
    logic [NP-1:0] mpf, mpen;
    logic [1:0] mpin;

    always #10 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .chg_evt_i(chg),
        .tmr_ovf_i(tmr), .periph_evt_i(pevt), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .gie_clr_i(clr), .rfi_i(rfi), .irq_req_o(req),
        .vec_take_o(take), .vec_addr_o(vaddr), .wake_o(wake)
    );

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        steps(3);
        rst_n = 1'b1;
        step();
    endtask

    function automatic logic exp_req();
        return mgie & ((|(mf & men)) | (mpge & (|(mpf & mpen))));
    endfunction

    function automatic logic exp_wake();
        return (|(mf & men & 3'b101)) | (mpge & (|(mpf & mpen)));
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {mgie, mpge, men[0], men[1], men[2], mf[0], mf[1], mf[2]};
            2'd1:    return {1'b0, mpf};
            2'd2:    return {1'b0, mpen};
            default: return {6'b0, mpin};
        endcase
    endfunction

    task automatic model_reset();
        mf = '0; men = '0; mgie = 0; mpge = 0; mvec = 0;
        mpf = '0; mpen = '0; mpin = '0;
    endtask

    // advance the model by one rising edge using the driven inputs
    task automatic model_edge();
        logic tk;
        tk = exp_req() & ~clr;
        mvec = tk;
        if (wr_en && wr_addr == 2'd0) begin
            mf  = {wr_data[0], wr_data[1], wr_data[2]};
            men = {wr_data[3], wr_data[4], wr_data[5]};
            mpge = wr_data[6];
        end
        mf[1] = mf[1] | tmr;
        mf[2] = mf[2] | chg;
        if (wr_en && wr_addr == 2'd1) mpf = wr_data[NP-1:0];
        mpf = mpf | pevt;
        if (wr_en && wr_addr == 2'd2) mpen = wr_data[NP-1:0];
        if (wr_en && wr_addr == 2'd3) mpin = wr_data[1:0];
        if (tk | clr) mgie = 0;
        else if (rfi) mgie = 1;
        else if (wr_en && wr_addr == 2'd0) mgie = wr_data[7];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_err++;
                n_chk++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1 reg", d, 8'h00);
        end
        chk("R1 req", req, 0);
        chk("R1 take", take, 0);
        chk("R1 wake", wake, 0);

        // R8 rising edge, flag appears on the third edge
        wr(2'd3, 8'h01);
        ext_pin = 1'b1;
        steps(2);
        rd(2'd0, d); chk("R8 rise early", d[2], 0);
        step();
        rd(2'd0, d); chk("R8 rise third edge", d[2], 1);
        wr(2'd0, 8'h00);
        ext_pin = 1'b0;
        steps(5);
        rd(2'd0, d); chk("R8 falling ignored in rising mode", d[2], 0);

        // R8 falling edge
        wr(2'd3, 8'h00);
        ext_pin = 1'b1;
        steps(5);
        rd(2'd0, d); chk("R8 rising ignored in falling mode", d[2], 0);
        ext_pin = 1'b0;
        steps(2);
        rd(2'd0, d); chk("R8 fall early", d[2], 0);
        step();
        rd(2'd0, d); chk("R8 fall third edge", d[2], 1);
        wr(2'd0, 8'h00);

        // R9 analog mode blocks both edges
        wr(2'd3, 8'h03);
        ext_pin = 1'b1; steps(5);
        rd(2'd0, d); chk("R9 analog rise", d[2], 0);
        ext_pin = 1'b0; steps(5);
        rd(2'd0, d); chk("R9 analog fall", d[2], 0);
        wr(2'd3, 8'h00);

        // R2 flag sets with every enable clear
        tmr = 1'b1; step(); tmr = 1'b0;
        rd(2'd0, d); chk("R2 timer flag", d[1], 1);
        chk("R2 no request", req, 0);
        // R3 event beats a clearing write
        tmr = 1'b1; wr(2'd0, 8'h00); tmr = 1'b0;
        rd(2'd0, d); chk("R3 event wins", d[1], 1);
        steps(3);
        rd(2'd0, d); chk("R3 sticky", d[1], 1);
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk("R3 software clear", d[1], 0);

        // R4 gating by global and group enables, R5 dispatch
        pevt = 7'h08; step(); pevt = '0;
        rd(2'd1, d); chk("R2 periph flag", d, 8'h08);
        wr(2'd2, 8'h08);
        chk("R4 no gie", req, 0);
        wr(2'd0, 8'h80);
        chk("R4 no group enable", req, 0);
        chk("R4 no take", take, 0);
        wr(2'd0, 8'hC0);
        chk("R4 request", req, 1);
        chk("R5 not yet", take, 0);
        step();
        chk("R5 take", take, 1);
        chk("R5 vector", vaddr, 13'h0004);
        rd(2'd0, d); chk("R5 gie cleared", d[7], 0);
        step();
        chk("R5 single pulse", take, 0);

        // R7 return re-triggers a flag left set
        rfi = 1'b1; step(); rfi = 1'b0;
        chk("R7 request again", req, 1);
        step();
        chk("R7 take again", take, 1);

        // R6 clear strobe blocks the same-cycle dispatch
        rfi = 1'b1; step(); rfi = 1'b0;
        chk("R6 request before clear", req, 1);
        clr = 1'b1; step(); clr = 1'b0;
        chk("R6 blocked", take, 0);
        rd(2'd0, d); chk("R6 gie off", d[7], 0);
        rd(2'd1, d); chk("R6 still pending", d, 8'h08);
        rfi = 1'b1; step(); rfi = 1'b0;
        step();
        chk("R6 served later", take, 1);

        // R10 wake rules
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        tmr = 1'b1; step(); tmr = 1'b0;
        wr(2'd0, 8'h12);
        chk("R10 timer cannot wake", wake, 0);
        wr(2'd0, 8'h08);
        chg = 1'b1; step(); chg = 1'b0;
        chk("R10 pin change wakes", wake, 1);
        chk("R10 no request without gie", req, 0);
        wr(2'd0, 8'h00);
        pevt = 7'h01; step(); pevt = '0;
        wr(2'd2, 8'h01);
        chk("R10 group enable needed", wake, 0);
        wr(2'd0, 8'h40);
        chk("R10 peripheral wakes", wake, 1);

        // random phase against the model
        do_reset();
        model_reset();
        for (int c = 0; c < 4000; c++) begin
            rd(c[1:0], d);
            chk("R11 read", d, exp_rd(c[1:0]));
            chk("R4 request", req, exp_req());
            chk("R5 take", take, mvec);
            chk("R10 wake", wake, exp_wake());
            tmr   = ($urandom % 8) == 0;
            chg   = ($urandom % 8) == 0;
            pevt  = NP'($urandom) & NP'($urandom) & NP'($urandom);
            rfi   = ($urandom % 12) == 0;
            clr   = ($urandom % 24) == 0;
            wr_en = ($urandom % 5) == 0;
            wr_addr = 2'($urandom);
            wr_data = 8'($urandom);
            @(posedge clk);
            model_edge();
            @(negedge clk);
        end
        tmr = 0; chg = 0; pevt = '0; rfi = 0; clr = 0; wr_en = 0;
        finish_run();
    end
endmodule